// File: doc/BRIEF.md
# Multi-Lane Edge Detector Bank

This block watches a bus of up to 256 monitored signals and reports selected transitions on each one. Every lane carries a two-bit detection mode (rising, falling, both, or off) and a one-bit suppress flag. The inputs are registered once, and each sample is compared with the one before it. The block drives a per-lane event vector plus a combined any-event flag. Each event lasts one clock cycle.

Configuration is indirect. Software first writes a lane number into the selector register. Writes to the mode port or the suppress port then land on that lane only. All modes can be read back as sixteen packed 32-bit words, and all suppress flags as eight packed 32-bit words. The selected lane's own mode and flag can also be read directly. Values that the fields cannot hold are refused, and the stored state stays as it was.

Top module: `edge_watch_bank`

## Requirements
- R1: After a synchronous reset the lane selector is 0, every lane mode is 0 (rising), every suppress flag is 0, and `evt_o` and `any_evt_o` are low.
- R2: A lane in mode 0 flags an event only when its sample goes from 0 to 1.
- R3: A lane in mode 1 flags an event only when its sample goes from 1 to 0.
- R4: A lane in mode 2 flags an event on any change of its sample.
- R5: Mode 3 is reserved: a lane holding it never flags an event.
- R6: A lane whose suppress flag is 1 never flags an event, whatever its mode.
- R7: Register writes work as follows:
  - Writing address 0 sets the lane selector.
  - Writing address 1 stores `wr_data_i[1:0]` as the mode of the selected lane only.
  - Writing address 2 stores `wr_data_i[0]` as the suppress flag of the selected lane only.
  - Reading addresses 0, 1 and 2 returns the selector, the selected lane's mode and the selected lane's flag.
- R8: Some writes are ignored and leave all state unchanged:
  - a selector value not below the lane count;
  - a mode value above 3;
  - a suppress value above 1.
- R9: Reading address 16+w returns mode word w, where lane n's mode sits at bits 2*(n%16)+1:2*(n%16) of word n/16. Reading address 32+w returns flag word w, where lane n's flag sits at bit n%32 of word n/32. Bits for lanes that do not exist, and all other addresses, read as 0.
- R10: The event for an input change made before clock edge k shows on `evt_o` after edge k+1, for exactly one cycle. `any_evt_o` is the OR of `evt_o` in the same cycle.
- R11: The first sample taken after reset only primes the comparison, so no event follows reset whatever level the inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 6 | Register read address (combinational read) |
| rd_data_o | output | 32 | Register read data |
| sig_i | input | NUM_LANES | Monitored signals |
| evt_o | output | NUM_LANES | Per-lane one-cycle event flags |
| any_evt_o | output | 1 | OR of all lane events |

## Verification
The bench sweeps every mode and flag combination over all lanes of a 20-lane build. It compares each cycle's event vector against values computed from the previous and current samples.

- A bit-position slip in the packed words would move a lane's mode into its neighbour's field, and the full read-back of all words would expose it.
- Priming the comparison from zero instead of from the first sample would raise a burst of rising events right after reset while the inputs are held high.
- An extra register stage, or a missing one, shifts every event by a cycle against the expected history.
- Dropping the range check on the selector, or the value check on a write, would corrupt the stored index, mode or flag. The direct read-back catches both.

// File: rtl/edge_bank_pkg.sv
package edge_bank_pkg;

    localparam int REG_W          = 32;
    localparam int ADDR_W         = 6;
    localparam int IDX_W          = 8;
    localparam int MAX_LANES      = 1 << IDX_W;
    localparam int MODE_W         = 2;
    localparam int MODES_PER_WORD = REG_W / MODE_W;
    localparam int FLAGS_PER_WORD = REG_W;
    localparam int CTRL_WORDS     = MAX_LANES / MODES_PER_WORD;
    localparam int FLAG_WORDS     = MAX_LANES / FLAGS_PER_WORD;
    localparam int CW_SEL_W       = $clog2(CTRL_WORDS);
    localparam int FW_SEL_W       = $clog2(FLAG_WORDS);

    localparam logic [ADDR_W-1:0] ADR_SELECT = 6'd0;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 6'd1;
    localparam logic [ADDR_W-1:0] ADR_FLAG   = 6'd2;
    localparam logic [ADDR_W-1:0] ADR_CTRL0  = 6'd16;
    localparam logic [ADDR_W-1:0] ADR_FLAGW0 = 6'd32;

    typedef enum logic [MODE_W-1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_OFF  = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } reg_wr_t;

    function automatic logic lane_hit(input edge_mode_e mode, input logic prev, input logic cur);
        logic hit;
        case (mode)
            EDGE_RISE: hit = !prev && cur;
            EDGE_FALL: hit = prev && !cur;
            EDGE_BOTH: hit = prev ^ cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base,
                                       input int count);
        return (addr >= base) && (addr < base + ADDR_W'(count));
    endfunction

endpackage

// File: rtl/edge_bank_cfg.sv
module edge_bank_cfg
    import edge_bank_pkg::*;
#(
    parameter int NUM_LANES = 256
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  reg_wr_t                     wr_i,
    input  logic [ADDR_W-1:0]           rd_addr_i,
    output logic [REG_W-1:0]            rd_data_o,
    output logic [NUM_LANES*MODE_W-1:0] mode_flat_o,
    output logic [NUM_LANES-1:0]        flag_o
);

    logic [IDX_W-1:0] sel_q;
    logic             sel_ok;
    logic             mode_ok;
    logic             flag_ok;
    logic             wr_sel;
    logic             wr_mode;
    logic             wr_flag;

    assign sel_ok  = wr_i.data < REG_W'(NUM_LANES);
    assign mode_ok = wr_i.data[REG_W-1:MODE_W] == '0;
    assign flag_ok = wr_i.data[REG_W-1:1] == '0;
    assign wr_sel  = wr_i.en && (wr_i.addr == ADR_SELECT) && sel_ok;
    assign wr_mode = wr_i.en && (wr_i.addr == ADR_MODE) && mode_ok;
    assign wr_flag = wr_i.en && (wr_i.addr == ADR_FLAG) && flag_ok;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q <= '0;
        end else if (wr_sel) begin
            sel_q <= wr_i.data[IDX_W-1:0];
        end
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic              hit_sel;
        logic [MODE_W-1:0] mode_q;
        logic              flag_q;

        assign hit_sel = (sel_q == IDX_W'(l));

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                mode_q <= EDGE_RISE;
                flag_q <= 1'b0;
            end else begin
                if (wr_mode && hit_sel) begin
                    mode_q <= wr_i.data[MODE_W-1:0];
                end
                if (wr_flag && hit_sel) begin
                    flag_q <= wr_i.data[0];
                end
            end
        end

        assign mode_flat_o[l*MODE_W +: MODE_W] = mode_q;
        assign flag_o[l]                       = flag_q;
    end

    // Read side: pad the lane state out to the full map, then slice words.
    logic [CTRL_WORDS-1:0][REG_W-1:0]       ctrl_words;
    logic [FLAG_WORDS-1:0][REG_W-1:0]       flag_words;
    logic [MAX_LANES-1:0][MODE_W-1:0]       mode_all;
    logic [MAX_LANES-1:0]                   flag_all;
    logic [ADDR_W-1:0]                      ctrl_off;
    logic [ADDR_W-1:0]                      flag_off;

    always_comb begin
        ctrl_words = (CTRL_WORDS*REG_W)'(mode_flat_o);
        flag_words = (FLAG_WORDS*REG_W)'(flag_o);
        mode_all   = (MAX_LANES*MODE_W)'(mode_flat_o);
        flag_all   = MAX_LANES'(flag_o);
    end

    assign ctrl_off = rd_addr_i - ADR_CTRL0;
    assign flag_off = rd_addr_i - ADR_FLAGW0;

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADR_SELECT) begin
            rd_data_o = REG_W'(sel_q);
        end else if (rd_addr_i == ADR_MODE) begin
            rd_data_o = REG_W'(mode_all[sel_q]);
        end else if (rd_addr_i == ADR_FLAG) begin
            rd_data_o = REG_W'(flag_all[sel_q]);
        end else if (in_window(rd_addr_i, ADR_CTRL0, CTRL_WORDS)) begin
            rd_data_o = ctrl_words[ctrl_off[CW_SEL_W-1:0]];
        end else if (in_window(rd_addr_i, ADR_FLAGW0, FLAG_WORDS)) begin
            rd_data_o = flag_words[flag_off[FW_SEL_W-1:0]];
        end
    end

    // R7
    sel_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sel_q < IDX_W'(NUM_LANES - 1) || sel_q == IDX_W'(NUM_LANES - 1));

    // R8
    bad_flag_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i.en && wr_i.addr == ADR_FLAG && !flag_ok) |=> $stable(flag_o));

    // R8
    bad_mode_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i.en && wr_i.addr == ADR_MODE && !mode_ok) |=> $stable(mode_flat_o));

endmodule

// File: rtl/edge_bank_sampler.sv
module edge_bank_sampler
    import edge_bank_pkg::*;
#(
    parameter int NUM_LANES = 256
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_LANES-1:0] sig_i,
    output logic [NUM_LANES-1:0] cur_o,
    output logic [NUM_LANES-1:0] prev_o,
    output logic                 pair_vld_o
);

    logic cur_vld_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_o      <= '0;
            prev_o     <= '0;
            cur_vld_q  <= 1'b0;
            pair_vld_o <= 1'b0;
        end else begin
            cur_o      <= sig_i;
            prev_o     <= cur_o;
            cur_vld_q  <= 1'b1;
            pair_vld_o <= cur_vld_q;
        end
    end

endmodule

// File: rtl/edge_bank_detect.sv
module edge_bank_detect
    import edge_bank_pkg::*;
#(
    parameter int NUM_LANES = 256
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [NUM_LANES-1:0]        cur_i,
    input  logic [NUM_LANES-1:0]        prev_i,
    input  logic                        pair_vld_i,
    input  logic [NUM_LANES*MODE_W-1:0] mode_flat_i,
    input  logic [NUM_LANES-1:0]        flag_i,
    output logic [NUM_LANES-1:0]        evt_o,
    output logic                        any_o
);

    logic [NUM_LANES-1:0] hit;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        edge_mode_e mode;
        assign mode   = edge_mode_e'(mode_flat_i[l*MODE_W +: MODE_W]);
        assign hit[l] = !flag_i[l] && lane_hit(mode, prev_i[l], cur_i[l]);

        // R5
        reserved_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            ($past(mode_flat_i[l*MODE_W +: MODE_W]) == 2'd3) |-> !evt_o[l]);

        // R2
        rise_shape_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (evt_o[l] && $past(mode_flat_i[l*MODE_W +: MODE_W]) == 2'd0)
                |-> ($past(cur_i[l]) && !$past(prev_i[l])));

        // R3
        fall_shape_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (evt_o[l] && $past(mode_flat_i[l*MODE_W +: MODE_W]) == 2'd1)
                |-> (!$past(cur_i[l]) && $past(prev_i[l])));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            evt_o <= '0;
            any_o <= 1'b0;
        end else begin
            evt_o <= pair_vld_i ? hit : '0;
            any_o <= pair_vld_i && (|hit);
        end
    end

    // R6
    flagged_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_o & $past(flag_i)) == '0);

endmodule

// File: rtl/edge_watch_bank.sv
module edge_watch_bank
    import edge_bank_pkg::*;
#(
    parameter int NUM_LANES = 256
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 wr_en_i,
    input  logic [5:0]           wr_addr_i,
    input  logic [31:0]          wr_data_i,
    input  logic [5:0]           rd_addr_i,
    output logic [31:0]          rd_data_o,
    input  logic [NUM_LANES-1:0] sig_i,
    output logic [NUM_LANES-1:0] evt_o,
    output logic                 any_evt_o
);

    reg_wr_t                     wr;
    logic [NUM_LANES*MODE_W-1:0] mode_flat;
    logic [NUM_LANES-1:0]        flag;
    logic [NUM_LANES-1:0]        cur;
    logic [NUM_LANES-1:0]        prev;
    logic                        pair_vld;

    assign wr = '{en: wr_en_i, addr: wr_addr_i, data: wr_data_i};

    edge_bank_cfg #(.NUM_LANES(NUM_LANES)) u_cfg (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_i        (wr),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .mode_flat_o (mode_flat),
        .flag_o      (flag)
    );

    edge_bank_sampler #(.NUM_LANES(NUM_LANES)) u_smp (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sig_i      (sig_i),
        .cur_o      (cur),
        .prev_o     (prev),
        .pair_vld_o (pair_vld)
    );

    edge_bank_detect #(.NUM_LANES(NUM_LANES)) u_det (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cur_i       (cur),
        .prev_i      (prev),
        .pair_vld_i  (pair_vld),
        .mode_flat_i (mode_flat),
        .flag_i      (flag),
        .evt_o       (evt_o),
        .any_o       (any_evt_o)
    );

    // R10
    any_matches_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        any_evt_o == (|evt_o));

    // R11
    first_sample_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |=> (evt_o == '0));

endmodule

// File: tb/edge_watch_bank_tb.sv
`timescale 1ns/1ps
module edge_watch_bank_tb;

    localparam int NL = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [5:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NL-1:0] sig = '0;
    logic [NL-1:0] evt;
    logic          any_evt;

    int checks = 0;
    int fails  = 0;
    int mode_cfg [NL];
    bit flag_cfg [NL];
    int unsigned rng = 32'h1badf00d;

    always #4 clk = ~clk;

    edge_watch_bank #(.NUM_LANES(NL)) u_dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .sig_i     (sig),
        .evt_o     (evt),
        .any_evt_o (any_evt)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, $sformatf("read addr %0d", a), rd_data, exp);
    endtask

    function automatic logic [31:0] ctrl_word_exp(input int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 16; b++) begin
            if (w*16 + b < NL) v[2*b +: 2] = 2'(mode_cfg[w*16 + b]);
        end
        return v;
    endfunction

    function automatic logic [31:0] flag_word_exp(input int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 32; b++) begin
            if (w*32 + b < NL) v[b] = flag_cfg[w*32 + b];
        end
        return v;
    endfunction

    function automatic logic [NL-1:0] evt_exp(input logic [NL-1:0] p, input logic [NL-1:0] c);
        logic [NL-1:0] e = '0;
        for (int l = 0; l < NL; l++) begin
            if (!flag_cfg[l]) begin
                case (mode_cfg[l])
                    0: e[l] = !p[l] && c[l];
                    1: e[l] = p[l] && !c[l];
                    2: e[l] = p[l] ^ c[l];
                    default: e[l] = 1'b0;
                endcase
            end
        end
        return e;
    endfunction

    function automatic logic [NL-1:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[NL-1:0];
    endfunction

    // R2 R3 R4 R5 R6 R10: each cycle's events follow the sample pair two edges back
    task automatic run_stream(input int n);
        logic [NL-1:0] h1, h2, h3, v, e;
        h1 = sig; h2 = sig; h3 = sig;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            e = evt_exp(h3, h2);
            chk("R2 R3 R4 R5 R6 R10", "evt_o", 32'(evt), 32'(e));
            chk("R10", "any_evt_o", 32'(any_evt), 32'(|e));
            if (i >= n - 4)       v = h1;
            else if ((i % 8) < 5) v = next_rand();
            else                  v = (i % 2) ? '1 : '0;
            sig = v;
            h3 = h2; h2 = h1; h1 = v;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) begin mode_cfg[l] = 0; flag_cfg[l] = 1'b0; end

        // R11: inputs held high across reset release must not raise rising events
        sig = '1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11", "evt_o after reset", 32'(evt), 32'h0);
            chk("R11", "any_evt_o after reset", 32'(any_evt), 32'h0);
        end

        // R1: reset state through the read port
        reg_check("R1", 6'd0, 32'h0);
        for (int w = 0; w < 16; w++) reg_check("R1", 6'(16 + w), 32'h0);
        for (int w = 0; w < 8; w++)  reg_check("R1", 6'(32 + w), 32'h0);

        // R7: indirect write to lane 7
        reg_write(6'd0, 32'd7);
        reg_write(6'd1, 32'd2);
        reg_write(6'd2, 32'd1);
        mode_cfg[7] = 2; flag_cfg[7] = 1'b1;
        reg_check("R7", 6'd0, 32'd7);
        reg_check("R7", 6'd1, 32'd2);
        reg_check("R7", 6'd2, 32'd1);
        reg_check("R7", 6'd16, ctrl_word_exp(0));
        reg_check("R7", 6'd32, flag_word_exp(0));

        // R8: refused writes leave state as it was
        reg_write(6'd0, 32'd20);
        reg_check("R8", 6'd0, 32'd7);
        reg_write(6'd0, 32'd255);
        reg_check("R8", 6'd0, 32'd7);
        reg_write(6'd1, 32'd6);
        reg_check("R8", 6'd1, 32'd2);
        reg_write(6'd2, 32'd2);
        reg_check("R8", 6'd2, 32'd1);
        reg_write(6'd0, 32'd19);
        reg_check("R8", 6'd0, 32'd19);

        // Sweep every mode/flag combination across the lanes
        for (int k = 0; k < 4; k++) begin
            for (int l = 0; l < NL; l++) begin
                mode_cfg[l] = (l + k) % 4;
                flag_cfg[l] = ((l*3 + k) % 5) == 0;
                reg_write(6'd0, 32'(l));
                reg_write(6'd1, 32'(mode_cfg[l]));
                reg_write(6'd2, 32'(flag_cfg[l]));
            end
            // R9: packed read-back, lanes past the end and unmapped addresses
            for (int w = 0; w < 16; w++) reg_check("R9", 6'(16 + w), ctrl_word_exp(w));
            for (int w = 0; w < 8; w++)  reg_check("R9", 6'(32 + w), flag_word_exp(w));
            reg_check("R9", 6'd5, 32'h0);
            reg_check("R9", 6'd48, 32'h0);
            run_stream(64);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule